// File: doc/BRIEF.md
# Dual-Accumulator Register and Arithmetic Datapath

This block is the register file and arithmetic slice of a small 8-bit controller core. It holds two 8-bit accumulators, A and B, that together form the 16-bit double accumulator D. It also holds two 16-bit index registers, X and Y, and an 8-bit flag register. A sequencer outside the block issues one command per clock on a command port. The block applies that command at the next rising edge.

The commands cover the following:
- loads of A, B, D, X and Y;
- the one-directional A-with-B add, subtract and compare;
- adding B to an index register;
- swapping D with an index register;
- moving a byte between A and the flags;
- decimal adjust of A after a BCD addition.

A separate combinational output forms an indexed effective address from X or Y plus an 8-bit offset. Fetch, decode, memory traffic and interrupt entry are not part of this block.

Top module: `dacc_datapath`

## Requirements
- R1: While rst_n is low, and at the first edge after it is released, A, B, X and Y read zero and the flag register reads 8'hD0.
- R2: acc_d always equals {acc_a, acc_b}. Op 3 (load D) writes cmd_data[15:8] to A and cmd_data[7:0] to B. Op 1 loads A and op 2 loads B from cmd_data[7:0], each leaving the other byte unchanged. Ops 4 and 5 load X and Y from cmd_data. No load changes the flags.
- R3: The flag register layout, from bit 7 down to bit 0, is stop-disable, X-mask, half-carry H, I-mask, negative N, zero Z, overflow V, carry C.
- R4: Op 6 sets A to (A+B) mod 256. It sets H to the carry out of bit 3 and C to the carry out of bit 7. It sets V to two's-complement overflow, N to result bit 7 and Z when the result is zero.
- R5: Op 7 sets A to (A-B) mod 256. It sets C when A < B unsigned and V on signed overflow. N and Z follow the result, and H is unchanged.
- R6: Op 8 sets N, Z, V and C exactly as op 7 would, and leaves A and B unchanged.
- R7: Op 9 sets X to (X + zero-extended B) mod 65536, and op 10 does the same for Y. Both leave the flags and the accumulators unchanged.
- R8: Op 11 swaps D with X and op 12 swaps D with Y, each in one cycle. Neither changes the flags.
- R9: Op 13 copies all 8 bits of A into the flag register. Op 14 copies the flag register into A and leaves the flags unchanged.
- R10: Op 15 adds a correction to A. The low-digit correction is 6 when H is set or the low digit is above 9. The high-digit correction is 6 when C is set, the high digit is above 9, or the high digit is above 8 with the low digit above 9. C becomes C OR (high correction applied), N and Z follow the result, and H and V are unchanged.
- R11: ea_addr equals (ea_sel_y ? Y : X) plus the zero-extended ea_offset, mod 65536, in the same cycle.
- R12: With cmd_valid low, or with op 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code (0..15) |
| cmd_data | input | 16 | Load value |
| ea_sel_y | input | 1 | Effective address base: 1 selects Y, 0 selects X |
| ea_offset | input | 8 | Unsigned address offset |
| acc_a | output | 8 | Accumulator A |
| acc_b | output | 8 | Accumulator B |
| acc_d | output | 16 | Double accumulator {A,B} |
| idx_x | output | 16 | Index register X |
| idx_y | output | 16 | Index register Y |
| ccr | output | 8 | Flag register |
| ea_addr | output | 16 | Indexed effective address |

## Verification
The bench targets several boundary cases, and each one exposes a specific kind of wrong design:
- Nibble and byte carry boundaries such as 0x0F+0x01 and 0x7F+0x01. A design that took H from the wrong bit, or computed V from unsigned operands, would show a wrong flag after these.
- Subtracts with A below B. A design that inverted the borrow sense would show C wrong here.
- Compares. A design that wrote the difference back would change A.
- B values of 0x80 and above added to an index near 0xFFFF. A design that sign-extended B, or failed to wrap, would give the wrong index.
- Decimal adjust with H or C preset. A design that missed a preset carry would skip a correction.
- Swaps. A design that swapped half of D, or took two cycles, would leave a mismatched byte.

Random command streams mixed with these cases also catch any operation that disturbs a register it should leave alone.

// File: rtl/dacc_pkg.sv
// Shared constants and types for the dual-accumulator datapath.
// Assumes an 8-bit accumulator and 16-bit index/address width.
package dacc_pkg;
    localparam int ACC_W = 8;
    localparam int IDX_W = 2 * ACC_W;
    localparam int OP_W  = 4;

    // Flag register bit positions (fixed layout)
    localparam int FLG_S = 7;
    localparam int FLG_X = 6;
    localparam int FLG_H = 5;
    localparam int FLG_I = 4;
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

    localparam logic [ACC_W-1:0] FLAGS_RESET = 8'hD0;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_LDA  = 4'd1,
        OP_LDB  = 4'd2,
        OP_LDD  = 4'd3,
        OP_LDX  = 4'd4,
        OP_LDY  = 4'd5,
        OP_ADDAB = 4'd6,
        OP_SUBAB = 4'd7,
        OP_CMPAB = 4'd8,
        OP_BTOX = 4'd9,
        OP_BTOY = 4'd10,
        OP_SWPX = 4'd11,
        OP_SWPY = 4'd12,
        OP_A2F  = 4'd13,
        OP_F2A  = 4'd14,
        OP_DECA = 4'd15
    } dacc_op_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_DEC = 2'd2
    } alu_mode_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } alu_flags_t;
endpackage

// File: rtl/dacc_alu8.sv
// 8-bit arithmetic unit: add, subtract and BCD decimal adjust.
// Purely combinational. Assumes the caller decides which flags to keep;
// h/v outputs in decimal-adjust mode echo the inputs.
module dacc_alu8
    import dacc_pkg::*;
(
    input  alu_mode_e        mode,
    input  logic [ACC_W-1:0] opa,
    input  logic [ACC_W-1:0] opb,
    input  logic             h_in,
    input  logic             c_in,
    input  logic             v_in,
    output logic [ACC_W-1:0] res,
    output alu_flags_t       flg
);
    logic [ACC_W:0]   wide_sum;
    logic [ACC_W:0]   wide_dif;
    logic [4:0]       nib_sum;
    logic             lo_big;
    logic             hi_fix;
    logic [ACC_W-1:0] fix;

    // Compute result and flags for the selected mode
    always_comb begin
        wide_sum = {1'b0, opa} + {1'b0, opb};
        wide_dif = {1'b0, opa} - {1'b0, opb};
        nib_sum  = {1'b0, opa[3:0]} + {1'b0, opb[3:0]};
        lo_big   = (opa[3:0] > 4'd9);
        hi_fix   = c_in | (opa[7:4] > 4'd9) | ((opa[7:4] > 4'd8) & lo_big);
        fix      = {(hi_fix ? 4'h6 : 4'h0), ((h_in | lo_big) ? 4'h6 : 4'h0)};
        res      = '0;
        flg      = '0;
        unique case (mode)
            ALU_ADD: begin
                res   = wide_sum[ACC_W-1:0];
                flg.h = nib_sum[4];
                flg.c = wide_sum[ACC_W];
                flg.v = (opa[7] & opb[7] & ~res[7]) | (~opa[7] & ~opb[7] & res[7]);
            end
            ALU_SUB: begin
                res   = wide_dif[ACC_W-1:0];
                flg.h = h_in;
                flg.c = wide_dif[ACC_W];
                flg.v = (opa[7] & ~opb[7] & ~res[7]) | (~opa[7] & opb[7] & res[7]);
            end
            default: begin
                res   = opa + fix;
                flg.h = h_in;
                flg.c = hi_fix;
                flg.v = v_in;
            end
        endcase
        flg.n = res[ACC_W-1];
        flg.z = (res == '0);
    end
endmodule

// File: rtl/dacc_idx_add.sv
// Index adder: a wide base plus a zero-extended narrow offset, wrapping.
// Combinational; used for both index arithmetic and address formation.
module dacc_idx_add #(
    parameter int BASE_W = 16,
    parameter int OFF_W  = 8
) (
    input  logic [BASE_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output logic [BASE_W-1:0] sum
);
    localparam int PAD_W = BASE_W - OFF_W;

    // Zero-extend and add, discarding the carry out
    always_comb sum = base + {{PAD_W{1'b0}}, off};
endmodule

// File: rtl/dacc_datapath.sv
// Top of the dual-accumulator datapath. Holds A, B (D = {A,B}), X, Y and the
// flag register, and applies one command per clock. Assumes the issuer
// presents a stable command before the rising edge; reset is synchronous.
module dacc_datapath
    import dacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [IDX_W-1:0] cmd_data,
    input  logic             ea_sel_y,
    input  logic [ACC_W-1:0] ea_offset,
    output logic [ACC_W-1:0] acc_a,
    output logic [ACC_W-1:0] acc_b,
    output logic [IDX_W-1:0] acc_d,
    output logic [IDX_W-1:0] idx_x,
    output logic [IDX_W-1:0] idx_y,
    output logic [ACC_W-1:0] ccr,
    output logic [IDX_W-1:0] ea_addr
);
    logic [ACC_W-1:0] reg_a, reg_b, reg_f;
    logic [IDX_W-1:0] reg_x, reg_y;
    dacc_op_e         op;
    alu_mode_e        amode;
    logic [ACC_W-1:0] alu_res;
    alu_flags_t       alu_flg;
    logic [IDX_W-1:0] idx_sel, idx_sum, ea_base;

    // Decode the incoming command, treating an idle port as no-op
    always_comb op = cmd_valid ? dacc_op_e'(cmd_op) : OP_NOP;

    // Choose the arithmetic mode for the ALU
    always_comb begin
        unique case (op)
            OP_ADDAB: amode = ALU_ADD;
            OP_DECA:  amode = ALU_DEC;
            default:  amode = ALU_SUB;
        endcase
    end

    dacc_alu8 alu_i (
        .mode (amode),
        .opa  (reg_a),
        .opb  (reg_b),
        .h_in (reg_f[FLG_H]),
        .c_in (reg_f[FLG_C]),
        .v_in (reg_f[FLG_V]),
        .res  (alu_res),
        .flg  (alu_flg)
    );

    // Pick which index register receives B
    always_comb idx_sel = (op == OP_BTOY) ? reg_y : reg_x;
    // Pick the effective-address base
    always_comb ea_base = ea_sel_y ? reg_y : reg_x;

    dacc_idx_add #(.BASE_W(IDX_W), .OFF_W(ACC_W)) bidx_i (
        .base (idx_sel),
        .off  (reg_b),
        .sum  (idx_sum)
    );

    dacc_idx_add #(.BASE_W(IDX_W), .OFF_W(ACC_W)) ea_i (
        .base (ea_base),
        .off  (ea_offset),
        .sum  (ea_addr)
    );

    // Register update: one operation per clock, synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a <= '0;
            reg_b <= '0;
            reg_x <= '0;
            reg_y <= '0;
            reg_f <= FLAGS_RESET;
        end else begin
            unique case (op)
                OP_LDA: reg_a <= cmd_data[ACC_W-1:0];
                OP_LDB: reg_b <= cmd_data[ACC_W-1:0];
                OP_LDD: {reg_a, reg_b} <= cmd_data;
                OP_LDX: reg_x <= cmd_data;
                OP_LDY: reg_y <= cmd_data;
                OP_ADDAB: begin
                    reg_a        <= alu_res;
                    reg_f[FLG_H] <= alu_flg.h;
                    reg_f[FLG_N] <= alu_flg.n;
                    reg_f[FLG_Z] <= alu_flg.z;
                    reg_f[FLG_V] <= alu_flg.v;
                    reg_f[FLG_C] <= alu_flg.c;
                end
                OP_SUBAB, OP_CMPAB: begin
                    if (op == OP_SUBAB) reg_a <= alu_res;
                    reg_f[FLG_N] <= alu_flg.n;
                    reg_f[FLG_Z] <= alu_flg.z;
                    reg_f[FLG_V] <= alu_flg.v;
                    reg_f[FLG_C] <= alu_flg.c;
                end
                OP_BTOX: reg_x <= idx_sum;
                OP_BTOY: reg_y <= idx_sum;
                OP_SWPX: begin
                    reg_x          <= {reg_a, reg_b};
                    {reg_a, reg_b} <= reg_x;
                end
                OP_SWPY: begin
                    reg_y          <= {reg_a, reg_b};
                    {reg_a, reg_b} <= reg_y;
                end
                OP_A2F: reg_f <= reg_a;
                OP_F2A: reg_a <= reg_f;
                OP_DECA: begin
                    reg_a        <= alu_res;
                    reg_f[FLG_N] <= alu_flg.n;
                    reg_f[FLG_Z] <= alu_flg.z;
                    reg_f[FLG_C] <= reg_f[FLG_C] | alu_flg.c;
                end
                default: ;
            endcase
        end
    end

    // Drive register views to the ports
    always_comb begin
        acc_a = reg_a;
        acc_b = reg_b;
        acc_d = {reg_a, reg_b};
        idx_x = reg_x;
        idx_y = reg_y;
        ccr   = reg_f;
    end
endmodule

// File: rtl/dacc_datapath_chk.sv
// Port-level checker for dacc_datapath, attached with bind below.
module dacc_datapath_chk
    import dacc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [OP_W-1:0]  cmd_op,
    input logic [IDX_W-1:0] cmd_data,
    input logic             ea_sel_y,
    input logic [ACC_W-1:0] ea_offset,
    input logic [ACC_W-1:0] acc_a,
    input logic [ACC_W-1:0] acc_b,
    input logic [IDX_W-1:0] acc_d,
    input logic [IDX_W-1:0] idx_x,
    input logic [IDX_W-1:0] idx_y,
    input logic [ACC_W-1:0] ccr,
    input logic [IDX_W-1:0] ea_addr
);
    // R2: double-accumulator load splits across both bytes
    a_r2_load_d: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd3) |=> (acc_a == $past(cmd_data[15:8]) && acc_b == $past(cmd_data[7:0])));

    // R6: compare keeps both accumulators
    a_r6_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd8) |=> (acc_a == $past(acc_a) && acc_b == $past(acc_b)));

    // R7: B-to-index adds zero-extended B and leaves flags
    a_r7_btox_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd9) |=> (idx_x == $past(idx_x) + {8'h00, $past(acc_b)} && $stable(ccr)));

    // R8: swap with X exchanges both directions at once
    a_r8_swap_x: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd11) |=> (idx_x == $past(acc_d) && acc_d == $past(idx_x) && $stable(ccr)));

    // R8: swap with Y exchanges both directions at once
    a_r8_swap_y: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd12) |=> (idx_y == $past(acc_d) && acc_d == $past(idx_y) && $stable(ccr)));

    // R9: A-to-flags copies all bits
    a_r9_a_to_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd13) |=> (ccr == $past(acc_a)));

    // R12: idle port changes nothing
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid) |=> ($stable(acc_d) && $stable(idx_x) && $stable(idx_y) && $stable(ccr)));

    // R11: effective address tracks the chosen base
    a_r11_ea_form: assert property (@(posedge clk) disable iff (!rst_n)
        ea_addr == (ea_sel_y ? idx_y : idx_x) + {8'h00, ea_offset});
endmodule

bind dacc_datapath dacc_datapath_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .ea_sel_y(ea_sel_y), .ea_offset(ea_offset),
    .acc_a(acc_a), .acc_b(acc_b), .acc_d(acc_d), .idx_x(idx_x),
    .idx_y(idx_y), .ccr(ccr), .ea_addr(ea_addr)
);

// File: tb/dacc_datapath_tb_top.sv
`timescale 1ns/1ps
module dacc_datapath_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [15:0] cmd_data = 16'd0;
    logic        ea_sel_y = 1'b0;
    logic [7:0]  ea_offset = 8'd0;
    logic [7:0]  acc_a, acc_b, ccr;
    logic [15:0] acc_d, idx_x, idx_y, ea_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    logic [7:0]  m_a, m_b, m_f;
    logic [15:0] m_x, m_y;

    always #4 clk = ~clk;

    dacc_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .ea_sel_y(ea_sel_y), .ea_offset(ea_offset),
        .acc_a(acc_a), .acc_b(acc_b), .acc_d(acc_d), .idx_x(idx_x),
        .idx_y(idx_y), .ccr(ccr), .ea_addr(ea_addr)
    );

    function automatic string req_of(input int op);
        case (op)
            0: return "R12"; 1, 2, 3, 4, 5: return "R2";
            6: return "R4"; 7: return "R5"; 8: return "R6";
            9, 10: return "R7"; 11, 12: return "R8";
            13, 14: return "R9"; default: return "R10";
        endcase
    endfunction

    // Reference model of one command, from the requirements
    task automatic model(input bit vld, input int op, input logic [15:0] dat);
        int sa, sb, sr, lo, hi, corr;
        logic [7:0] r;
        logic [15:0] t;
        if (!vld) return;
        sa = int'($signed(m_a)); sb = int'($signed(m_b));
        case (op)
            1: m_a = dat[7:0];
            2: m_b = dat[7:0];
            3: begin m_a = dat[15:8]; m_b = dat[7:0]; end
            4: m_x = dat;
            5: m_y = dat;
            6: begin
                r = 8'(int'(m_a) + int'(m_b)); sr = sa + sb;
                m_f[5] = (int'(m_a % 16) + int'(m_b % 16)) > 15;
                m_f[0] = (int'(m_a) + int'(m_b)) > 255;
                m_f[1] = (sr > 127) || (sr < -128);
                m_f[3] = r[7]; m_f[2] = (r == 0); m_a = r;
            end
            7, 8: begin
                r = 8'(int'(m_a) - int'(m_b)); sr = sa - sb;
                m_f[0] = m_a < m_b;
                m_f[1] = (sr > 127) || (sr < -128);
                m_f[3] = r[7]; m_f[2] = (r == 0);
                if (op == 7) m_a = r;
            end
            9:  m_x = 16'(int'(m_x) + int'(m_b));
            10: m_y = 16'(int'(m_y) + int'(m_b));
            11: begin t = m_x; m_x = {m_a, m_b}; {m_a, m_b} = t; end
            12: begin t = m_y; m_y = {m_a, m_b}; {m_a, m_b} = t; end
            13: m_f = m_a;
            14: m_a = m_f;
            15: begin
                lo = int'(m_a % 16); hi = int'(m_a / 16); corr = 0;
                if (m_f[5] || lo > 9) corr += 6;
                if (m_f[0] || hi > 9 || (hi > 8 && lo > 9)) begin corr += 96; m_f[0] = 1'b1; end
                r = 8'(int'(m_a) + corr);
                m_f[3] = r[7]; m_f[2] = (r == 0); m_a = r;
            end
            default: ;
        endcase
    endtask

    task automatic compare(input string req);
        checks++;
        if ({acc_a, acc_b, idx_x, idx_y, ccr} !== {m_a, m_b, m_x, m_y, m_f} || acc_d !== {acc_a, acc_b}) begin
            fails++;
            $display("FAIL %s: got a=%h b=%h d=%h x=%h y=%h f=%h exp a=%h b=%h d=%h x=%h y=%h f=%h",
                     req, acc_a, acc_b, acc_d, idx_x, idx_y, ccr, m_a, m_b, {m_a, m_b}, m_x, m_y, m_f);
        end
    endtask

    task automatic check_ea(input bit sel, input logic [7:0] off);
        logic [15:0] exp;
        ea_sel_y = sel; ea_offset = off;
        #1;
        exp = 16'(int'(sel ? m_y : m_x) + int'(off));
        checks++;
        if (ea_addr !== exp) begin
            fails++;
            $display("FAIL R11: got ea=%h exp ea=%h", ea_addr, exp);
        end
    endtask

    // Drive at the falling edge, compare at the following falling edge
    task automatic run(input bit vld, input int op, input logic [15:0] dat);
        cmd_valid = vld; cmd_op = 4'(op); cmd_data = dat;
        model(vld, op, dat);
        @(negedge clk);
        cmd_valid = 1'b0;
        compare(vld ? req_of(op) : "R12");
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0C11);
        m_a = 0; m_b = 0; m_x = 0; m_y = 0; m_f = 8'hD0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
        check_ea(1'b0, 8'hFF);

        // Directed corner cases
        run(1, 3, 16'h0F01);   // R2
        run(1, 6, 0);          // R4 half carry
        run(1, 3, 16'h7F01);
        run(1, 6, 0);          // R4 signed overflow, H
        run(1, 3, 16'hFF01);
        run(1, 6, 0);          // R4 carry and zero
        run(1, 3, 16'h0102);
        run(1, 7, 0);          // R5 borrow
        run(1, 3, 16'h8001);
        run(1, 7, 0);          // R5 overflow
        run(1, 3, 16'h0505);
        run(1, 8, 0);          // R6 equal compare, A kept
        run(1, 4, 16'hFFF0);
        run(1, 3, 16'h0090);
        run(1, 9, 0);          // R7 zero-extend and wrap
        check_ea(1'b0, 8'h80);
        run(1, 5, 16'h1234);
        run(1, 10, 0);         // R7 Y
        check_ea(1'b1, 8'hCC);
        run(1, 3, 16'hABCD);
        run(1, 11, 0);         // R8 X swap
        run(1, 12, 0);         // R8 Y swap
        run(1, 1, 16'h002A);   // R3/R9 flag layout via A
        run(1, 13, 0);
        run(1, 1, 16'h0000);
        run(1, 14, 0);
        run(1, 3, 16'h3939);
        run(1, 6, 0);          // 39+39 = 72, H set
        run(1, 15, 0);         // R10 -> 78
        run(1, 1, 16'h0001);
        run(1, 13, 0);         // C preset
        run(1, 1, 16'h0012);
        run(1, 15, 0);         // R10 high correction from C
        run(1, 1, 16'h009A);
        run(1, 15, 0);         // R10 hi>8 with lo>9
        run(0, 6, 16'hFFFF);   // R12 idle
        run(1, 0, 16'hFFFF);   // R12 nop

        // Random stream
        for (int i = 0; i < 600; i++) begin
            run(($urandom % 8) != 0, int'($urandom % 16), 16'($urandom));
            if (i % 5 == 0) check_ea(1'($urandom), 8'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule